// File: doc/BRIEF.md
# Indirectly Configured Strobe Routing Matrix

The block steers a set of internal status and timing signals onto four external debug strobe pins, as software directs. Software programs the routing through one 16-bit control register on a simple write/read bus. Each write carries a signal number, an enable bit and a two-bit target pin code. The block keeps these in a per-signal configuration table, so one narrow register can program any number of routes.

Each strobe pin drives the OR of the current values of all enabled signals that target it. A pin with no such signal drives 0. The routing path is purely combinational from the source inputs and the stored table, so source edges reach the pins without clock delay.

A second write mode changes only the signal number and leaves the table as it is. This lets software point the register at any signal and read back that signal's stored enable and pin code. The number of implemented source signals is a parameter. Writes that name a signal beyond that count still move the selector, but they leave the table untouched.

Top module: `strb_route_matrix`

## Requirements
- R1: After reset the selector is 0, every signal is disabled with pin code 00, `rd_data` reads 0 and all four bits of `strb_o` are 0 whatever `src_i` holds.
- R2: A write with `wr_data[15]`=0 and a selector `wr_data[14:8]` below NUM_SRC stores `wr_data[4]` as the enable and `wr_data[1:0]` as the pin code of that signal. The new routing is in effect from the clock edge that takes the write.
- R3: A write with `wr_data[15]`=1 loads only the selector. The stored enable and pin code of every signal stay as they were, whatever bits 4 and 1:0 carry.
- R4: Pin code 00 routes the signal to `strb_o[0]`, 01 to `strb_o[1]`, 10 to `strb_o[2]` and 11 to `strb_o[3]`.
- R5: A signal whose stored enable is 0 reaches no strobe pin.
- R6: Each bit of `strb_o` is the OR of the current values of all enabled signals that carry its pin code. A pin with no enabled signal drives 0.
- R7: `rd_data` reads bit 15 as 0, bits 14:8 as the current selector, bit 4 as the stored enable and bits 1:0 as the stored pin code of the selected signal. All other bits read as 0.
- R8: A write whose selector is NUM_SRC or above loads the selector and leaves the table unchanged. While the selector is out of range, `rd_data` reads enable 0 and pin code 00.
- R9: A change on `src_i` shows on `strb_o` with no clock edge in between.
- R10: Each signal drives at most one pin. A new full write for a signal moves it away from its previous pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 16 | Control register write value |
| rd_data | output | 16 | Control register read value |
| src_i | input | NUM_SRC | Source signals to be routed |
| strb_o | output | 4 | Debug strobe pins |

## Verification
Two things can land in the same clock cycle: a table write that changes a signal's route, and a change on the source inputs. The bench provokes this by changing `src_i` in the same low phase as a random write. It then judges `strb_o` after the edge against a model that applies the new table to the new source values. Random traffic also mixes selector-only and out-of-range writes with full writes. After each one, `rd_data` and the pin outputs are compared with the model, so a write that changes the table when it should not is caught.

// File: rtl/strb_route_pkg.sv
package strb_route_pkg;
  localparam int REG_W     = 16;
  localparam int MODE_BIT  = 15;
  localparam int SEL_LSB   = 8;
  localparam int SEL_W     = 7;
  localparam int EN_BIT    = 4;
  localparam int PORT_LSB  = 0;
  localparam int PORT_W    = 2;
  localparam int NUM_PORTS = 1 << PORT_W;

  typedef struct packed {
    logic              en;
    logic [PORT_W-1:0] port;
  } strb_cfg_t;
endpackage

// File: rtl/strb_ctrl_reg.sv
module strb_ctrl_reg
  import strb_route_pkg::*;
#(
  parameter int NUM_SRC = 24,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  strb_cfg_t        sel_cfg,
  output logic [IDX_W-1:0] tbl_addr,
  output logic             tbl_we,
  output logic [IDX_W-1:0] tbl_waddr,
  output strb_cfg_t        tbl_wcfg,
  output logic [REG_W-1:0] rd_data
);
  logic [SEL_W-1:0] wr_sel;
  logic             wr_sel_ok;
  logic [SEL_W-1:0] sel_q;
  logic             sel_ok;
  logic             unused_bits;

  assign wr_sel      = wr_data[SEL_LSB +: SEL_W];
  assign wr_sel_ok   = (32'(wr_sel) < NUM_SRC);
  assign unused_bits = ^{wr_data[7:5], wr_data[3:2]};

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else if (wr_en) sel_q <= wr_sel;
  end

  assign tbl_we        = wr_en && !wr_data[MODE_BIT] && wr_sel_ok;
  assign tbl_waddr     = wr_sel[IDX_W-1:0];
  assign tbl_wcfg.en   = wr_data[EN_BIT];
  assign tbl_wcfg.port = wr_data[PORT_LSB +: PORT_W];

  assign sel_ok   = (32'(sel_q) < NUM_SRC);
  assign tbl_addr = sel_q[IDX_W-1:0];

  always_comb begin
    rd_data = '0;
    rd_data[SEL_LSB +: SEL_W] = sel_q;
    if (sel_ok) begin
      rd_data[EN_BIT]                = sel_cfg.en;
      rd_data[PORT_LSB +: PORT_W]    = sel_cfg.port;
    end
  end
endmodule

// File: rtl/strb_cfg_table.sv
module strb_cfg_table
  import strb_route_pkg::*;
#(
  parameter int NUM_SRC = 24,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [IDX_W-1:0]        waddr,
  input  strb_cfg_t               wcfg,
  input  logic [IDX_W-1:0]        raddr,
  output strb_cfg_t               rcfg,
  output strb_cfg_t [NUM_SRC-1:0] cfg_all
);
  strb_cfg_t [NUM_SRC-1:0] tbl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SRC; i++) tbl_q[i] <= '0;
    end else if (we) begin
      tbl_q[waddr] <= wcfg;
    end
  end

  always_comb begin
    rcfg = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (raddr == IDX_W'(i)) rcfg = tbl_q[i];
  end

  assign cfg_all = tbl_q;
endmodule

// File: rtl/strb_port_or.sv
module strb_port_or
  import strb_route_pkg::*;
#(
  parameter int NUM_SRC = 24
) (
  input  strb_cfg_t [NUM_SRC-1:0] cfg_all,
  input  logic [NUM_SRC-1:0]      src_i,
  output logic [NUM_PORTS-1:0]    strb_o
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [NUM_SRC-1:0] hit;
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign hit[s] = cfg_all[s].en && (cfg_all[s].port == PORT_W'(p)) && src_i[s];
    end
    assign strb_o[p] = |hit;
  end
endmodule

// File: rtl/strb_route_matrix.sv
module strb_route_matrix
  import strb_route_pkg::*;
#(
  parameter int NUM_SRC = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [15:0]        wr_data,
  output logic [15:0]        rd_data,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [3:0]         strb_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  strb_cfg_t               sel_cfg;
  strb_cfg_t               tbl_wcfg;
  strb_cfg_t [NUM_SRC-1:0] cfg_all;
  logic [IDX_W-1:0]        tbl_addr;
  logic [IDX_W-1:0]        tbl_waddr;
  logic                    tbl_we;

  strb_ctrl_reg #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .sel_cfg(sel_cfg), .tbl_addr(tbl_addr), .tbl_we(tbl_we),
    .tbl_waddr(tbl_waddr), .tbl_wcfg(tbl_wcfg), .rd_data(rd_data)
  );

  strb_cfg_table #(.NUM_SRC(NUM_SRC)) u_tbl (
    .clk(clk), .rst(rst), .we(tbl_we), .waddr(tbl_waddr), .wcfg(tbl_wcfg),
    .raddr(tbl_addr), .rcfg(sel_cfg), .cfg_all(cfg_all)
  );

  strb_port_or #(.NUM_SRC(NUM_SRC)) u_or (
    .cfg_all(cfg_all), .src_i(src_i), .strb_o(strb_o)
  );
endmodule

// File: rtl/strb_route_checker.sv
module strb_route_checker #(
  parameter int NUM_SRC = 24
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [15:0]        wr_data,
  input logic [15:0]        rd_data,
  input logic [NUM_SRC-1:0] src_i,
  input logic [3:0]         strb_o
);
  logic in_rng;
  assign in_rng = (32'(wr_data[14:8]) < NUM_SRC);

  // R1: first cycle after reset reads all zero
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_data == 16'h0 && strb_o == 4'h0));

  // R2: full in-range write is visible in readback
  p_full_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[15] && in_rng) |=>
      (rd_data[4] == $past(wr_data[4]) && rd_data[1:0] == $past(wr_data[1:0])));

  // R3: every write loads the selector
  p_sel_load_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data[14:8] == $past(wr_data[14:8]));

  // R7: unused readback bits are zero
  p_rd_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_data & 16'h80EC) == 16'h0);

  // R8: out-of-range selector reads enable and pin code as zero
  p_oor_read_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !in_rng) |=> rd_data[4:0] == 5'h0);

  // R3: without a write the readback cannot move
  p_idle_stable_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(rd_data));

  // R6: all sources low means every pin low
  p_src_low_r6: assert property (@(posedge clk) disable iff (rst)
    (src_i == '0) |-> strb_o == 4'h0);
endmodule

bind strb_route_matrix strb_route_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .src_i(src_i), .strb_o(strb_o)
);

// File: tb/strb_route_matrix_bench.sv
module strb_route_matrix_bench;
  localparam int NUM_SRC = 24;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               wr_en = 1'b0;
  logic [15:0]        wr_data = '0;
  logic [15:0]        rd_data;
  logic [NUM_SRC-1:0] src_i = '0;
  logic [3:0]         strb_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic       m_en   [NUM_SRC];
  logic [1:0] m_port [NUM_SRC];
  logic [6:0] m_sel;

  always #10 clk = ~clk;

  strb_route_matrix #(.NUM_SRC(NUM_SRC)) u_strb_route_matrix (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .src_i(src_i), .strb_o(strb_o)
  );

  function automatic logic [3:0] exp_strb(input logic [NUM_SRC-1:0] s);
    logic [3:0] r = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (m_en[i] && s[i]) r[m_port[i]] = 1'b1;
    return r;
  endfunction

  function automatic logic [15:0] exp_rd();
    logic [15:0] r = '0;
    r[14:8] = m_sel;
    if (int'(m_sel) < NUM_SRC) begin
      r[4]   = m_en[m_sel];
      r[1:0] = m_port[m_sel];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic mode, input int sel, input logic en, input logic [1:0] port,
                    input logic [NUM_SRC-1:0] s);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = {mode, 7'(sel), 3'b101, en, 2'b11, port};
    src_i   = s;
    @(negedge clk);
    wr_en = 1'b0;
    m_sel = 7'(sel);
    if (!mode && sel < NUM_SRC) begin
      m_en[sel]   = en;
      m_port[sel] = port;
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NUM_SRC; i++) begin m_en[i] = 0; m_port[i] = 0; end
    m_sel = 0;
    src_i = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rd", 32'(rd_data), 32'h0);
    chk("R1 strb", 32'(strb_o), 32'h0);
    for (int i = 0; i < NUM_SRC; i++) begin
      wr(1'b1, i, 1'b1, 2'b11, '1);
      chk("R1 table", 32'(rd_data), 32'(exp_rd()));
    end

    // R4 / R10: move one signal across all four pins
    for (int p = 0; p < 4; p++) begin
      wr(1'b0, 3, 1'b1, 2'(p), NUM_SRC'(1) << 3);
      chk("R4 R10 pin", 32'(strb_o), 32'(4'b1 << p));
      chk("R2 rd", 32'(rd_data), 32'({1'b0, 7'd3, 3'b0, 1'b1, 2'b0, 2'(p)}));
    end
    // R5
    wr(1'b0, 3, 1'b0, 2'b10, '1);
    chk("R5 disabled", 32'(strb_o), 32'h0);
    // R6
    wr(1'b0, 1, 1'b1, 2'b10, '0);
    wr(1'b0, 5, 1'b1, 2'b10, NUM_SRC'(1) << 1);
    chk("R6 or a", 32'(strb_o), 32'h4);
    src_i = NUM_SRC'(1) << 5; #1;
    chk("R6 or b R9", 32'(strb_o), 32'h4);
    src_i = NUM_SRC'(1) << 7; #1;
    chk("R6 none R9", 32'(strb_o), 32'h0);
    src_i = (NUM_SRC'(1) << 5) | (NUM_SRC'(1) << 1); #1;
    chk("R6 both R9", 32'(strb_o), 32'h4);
    // R3
    wr(1'b1, 5, 1'b0, 2'b01, (NUM_SRC'(1) << 5));
    chk("R3 rd", 32'(rd_data), 32'({1'b0, 7'd5, 3'b0, 1'b1, 2'b0, 2'b10}));
    chk("R3 strb", 32'(strb_o), 32'h4);
    // R8
    wr(1'b0, NUM_SRC + 2, 1'b1, 2'b01, '1);
    chk("R8 rd R7", 32'(rd_data), 32'({1'b0, 7'(NUM_SRC + 2), 8'h0}));
    chk("R8 strb", 32'(strb_o), 32'(exp_strb('1)));
    wr(1'b0, 127, 1'b1, 2'b00, '1);
    chk("R8 top sel", 32'(rd_data), 32'h7F00);

    // random traffic; source changes in the same cycle as the write
    for (int k = 0; k < 400; k++) begin
      logic [NUM_SRC-1:0] s;
      int sel;
      s   = NUM_SRC'($urandom);
      sel = int'($urandom % (NUM_SRC + 8));
      wr(1'($urandom % 4 == 0), sel, 1'($urandom), 2'($urandom), s);
      chk("R2 R6 rand strb", 32'(strb_o), 32'(exp_strb(s)));
      chk("R7 rand rd", 32'(rd_data), 32'(exp_rd()));
      s = NUM_SRC'($urandom); src_i = s; #1;
      chk("R9 rand strb", 32'(strb_o), 32'(exp_strb(s)));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule